// File: doc/BRIEF.md
# Low-Storage Guard and Prefix Swapper

This block screens one storage access per cycle against the protected low-storage windows and turns its real address into an absolute page frame. Two 512-byte windows are guarded: one at the start of page 0 and one at the start of page 1. Guarding is switched on by a control bit. When address translation is on, a private address space turns the guard off.

A store that lands inside a guarded window is rejected with a protection fault. Any access whose page starts a guarded window raises a flag that tells the caller not to cache write permission for that page. This applies to loads and fetches as well. Each response carries an exception-code word built from the page address, the access direction and the protection indicator.

The absolute frame is formed by swapping the 8 KiB block at address zero with the 8 KiB block at the prefix base. Results are registered and appear one cycle after the request, together with a one-cycle valid strobe.

Top module: `lap_prefix_map`

## Requirements
- R1: A store is guarded when its exact byte address is in 0..511 or 4096..4607. A store at 512..4095, at 4608 or above, or anywhere outside those two windows never faults.
- R2: With `lap_en` low, `prot_fault` and `wr_inval` are both 0 for every access.
- R3: With `xlate_on` low, the guard applies whatever the value of `priv_space`. With `xlate_on` high and `priv_space` high, the guard is suppressed. With `xlate_on` high and `priv_space` low, it applies.
- R4: `wr_inval` is 1 when the guard is active and the page-aligned address (low 12 bits cleared) lies in a guarded window. This holds for loads (`req_kind`=0), stores (1) and fetches (2) alike, so a load at byte 600 sets it without any fault.
- R5: `prot_fault` is 1 only for a guarded store. When it is 1, bit 7 (value 0x80) of `exc_code` is set; otherwise bit 7 is 0.
- R6: `exc_code` equals the page-aligned address ORed with 0x400 for a store, or with 0x800 for a load or fetch, plus bit 7 as given in R5.
- R7: `abs_addr` is a page frame, with its low 12 bits zero. For a page address below 0x2000 it equals that address plus the aligned prefix.
- R8: A page address in [prefix, prefix+0x2000) maps to that address minus the prefix. Every other page address passes through unchanged.
- R9: The low 13 bits of `prefix_base` are ignored, so the prefix is always 8 KiB aligned.
- R10: Outputs update one clock after a cycle with `req_valid` high, and `rsp_valid` pulses for that one cycle. Without a request, `rsp_valid` is 0 and the other outputs hold. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_kind | input | 2 | 0 load, 1 store, 2 instruction fetch |
| lap_en | input | 1 | Low-storage guard enable |
| xlate_on | input | 1 | Address translation mode bit |
| priv_space | input | 1 | Private-space bit of the selected space |
| prefix_base | input | ADDR_W | Prefix register (low 13 bits ignored) |
| rsp_valid | output | 1 | One-cycle result strobe |
| abs_addr | output | ADDR_W | Absolute page frame |
| prot_fault | output | 1 | Store hit a guarded window |
| exc_code | output | ADDR_W | Exception-code word |
| wr_inval | output | 1 | Do not cache write permission for this page |

## Verification
The protection check and the prefix swap act in the same cycle on the same address. A guarded store at byte 0..511 therefore faults while its absolute frame moves up to the prefix base, and an access at the prefix base lands on frame zero. The bench makes these overlaps happen by choosing small addresses, and addresses equal to or just above the prefix, under every combination of enable, translation and private-space bits. It compares each field on every clock against a reference written with plain integer arithmetic. Stores at the window edges (511, 512, 4607, 4608) are judged both for the fault and for the swapped frame that comes back in the same response.

// File: rtl/lapm_pkg.sv
package lapm_pkg;
   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_kind_e;

   localparam int unsigned DIR_STORE_BIT = 10;
   localparam int unsigned DIR_READ_BIT  = 11;
   localparam int unsigned GUARD_BIT     = 7;
endpackage

// File: rtl/lapm_window_hit.sv
module lapm_window_hit #(
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned PAGE_W  = 12,
   parameter int unsigned WIN_W   = 9,
   parameter int unsigned NUM_WIN = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int unsigned PN_W = ADDR_W - PAGE_W;

   logic [NUM_WIN-1:0] win_hit;

   generate
      if (WIN_W > PAGE_W) begin : g_bad_win
         $error("window must fit inside one page");
      end
      for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
         assign win_hit[i] = (addr[ADDR_W-1:PAGE_W] == PN_W'(i)) &&
                             (addr[PAGE_W-1:WIN_W] == '0);
      end
   endgenerate

   assign hit = |win_hit;
endmodule

// File: rtl/lapm_guard.sv
module lapm_guard #(
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned PAGE_W  = 12,
   parameter int unsigned WIN_W   = 9,
   parameter int unsigned NUM_WIN = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_store,
   input  logic              lap_en,
   input  logic              xlate_on,
   input  logic              priv_space,
   output logic              fault,
   output logic              inval
);
   logic [ADDR_W-1:0] page_addr;
   logic              exact_hit;
   logic              page_hit;
   logic              active;

   assign page_addr = {addr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};

   lapm_window_hit #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WIN_W(WIN_W), .NUM_WIN(NUM_WIN)
   ) u_exact (
      .addr (addr),
      .hit  (exact_hit)
   );

   lapm_window_hit #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WIN_W(WIN_W), .NUM_WIN(NUM_WIN)
   ) u_page (
      .addr (page_addr),
      .hit  (page_hit)
   );

   assign active = lap_en && (!xlate_on || !priv_space);
   assign inval  = active && page_hit;
   assign fault  = active && exact_hit && is_store;
endmodule

// File: rtl/lapm_prefix_swap.sv
module lapm_prefix_swap #(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned PAGE_W = 12,
   parameter int unsigned SWAP_W = 13
) (
   input  logic [ADDR_W-1:0] real_addr,
   input  logic [ADDR_W-1:0] prefix,
   output logic [ADDR_W-1:0] abs_page
);
   localparam int unsigned UP_W = ADDR_W - SWAP_W;

   logic [UP_W-1:0]   ra_up;
   logic [UP_W-1:0]   pfx_up;
   logic [ADDR_W-1:0] swapped;

   generate
      if (SWAP_W < PAGE_W) begin : g_bad_swap
         $error("swap block smaller than a page");
      end
   endgenerate

   assign ra_up  = real_addr[ADDR_W-1:SWAP_W];
   assign pfx_up = prefix[ADDR_W-1:SWAP_W];

   always_comb begin
      if (ra_up == '0) begin
         swapped = {pfx_up, real_addr[SWAP_W-1:0]};
      end else if (ra_up == pfx_up) begin
         swapped = {{UP_W{1'b0}}, real_addr[SWAP_W-1:0]};
      end else begin
         swapped = real_addr;
      end
   end

   assign abs_page = {swapped[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
endmodule

// File: rtl/lap_prefix_map.sv
module lap_prefix_map #(
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned PAGE_W  = 12,
   parameter int unsigned WIN_W   = 9,
   parameter int unsigned NUM_WIN = 2,
   parameter int unsigned SWAP_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_kind,
   input  logic              lap_en,
   input  logic              xlate_on,
   input  logic              priv_space,
   input  logic [ADDR_W-1:0] prefix_base,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] abs_addr,
   output logic              prot_fault,
   output logic [ADDR_W-1:0] exc_code,
   output logic              wr_inval
);
   import lapm_pkg::*;

   generate
      if (PAGE_W <= DIR_READ_BIT) begin : g_bad_page
         $error("page offset must hold the direction bits");
      end
      if (ADDR_W <= SWAP_W) begin : g_bad_addr
         $error("address narrower than swap block");
      end
   endgenerate

   logic              is_store;
   logic              g_fault;
   logic              g_inval;
   logic [ADDR_W-1:0] m_abs;
   logic [ADDR_W-1:0] page_addr;
   logic [ADDR_W-1:0] code_n;

   assign is_store  = (acc_kind_e'(req_kind) == ACC_STORE);
   assign page_addr = {req_addr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};

   lapm_guard #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WIN_W(WIN_W), .NUM_WIN(NUM_WIN)
   ) u_guard (
      .addr       (req_addr),
      .is_store   (is_store),
      .lap_en     (lap_en),
      .xlate_on   (xlate_on),
      .priv_space (priv_space),
      .fault      (g_fault),
      .inval      (g_inval)
   );

   lapm_prefix_swap #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SWAP_W(SWAP_W)
   ) u_swap (
      .real_addr (page_addr),
      .prefix    (prefix_base),
      .abs_page  (m_abs)
   );

   always_comb begin
      code_n = page_addr;
      code_n[DIR_STORE_BIT] = is_store;
      code_n[DIR_READ_BIT]  = !is_store;
      code_n[GUARD_BIT]     = g_fault;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         abs_addr   <= '0;
         prot_fault <= 1'b0;
         exc_code   <= '0;
         wr_inval   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            abs_addr   <= m_abs;
            prot_fault <= g_fault;
            exc_code   <= code_n;
            wr_inval   <= g_inval;
         end
      end
   end
endmodule

// File: rtl/lapm_chk.sv
module lapm_chk #(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned PAGE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_kind,
   input logic              lap_en,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] abs_addr,
   input logic              prot_fault,
   input logic [ADDR_W-1:0] exc_code,
   input logic              wr_inval
);
   // R10
   strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid) |-> (!rsp_valid && $stable(abs_addr) && $stable(exc_code)));

   // R5
   fault_store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && prot_fault) |-> ($past(req_kind) == 2'd1));

   // R4
   fault_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prot_fault |-> wr_inval);

   // R5
   guard_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (exc_code[7] == prot_fault));

   // R6
   dir_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($countones(exc_code[11:10]) == 1));

   // R2
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !$past(lap_en)) |-> (!prot_fault && !wr_inval));

   // R7
   frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (abs_addr[PAGE_W-1:0] == '0));
endmodule

bind lap_prefix_map lapm_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_kind   (req_kind),
   .lap_en     (lap_en),
   .rsp_valid  (rsp_valid),
   .abs_addr   (abs_addr),
   .prot_fault (prot_fault),
   .exc_code   (exc_code),
   .wr_inval   (wr_inval)
);

// File: tb/sim_lap_prefix_map.sv
module sim_lap_prefix_map;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = '0;
   logic [1:0]  req_kind = 2'd0;
   logic        lap_en = 1'b0;
   logic        xlate_on = 1'b0;
   logic        priv_space = 1'b0;
   logic [63:0] prefix_base = '0;
   logic        rsp_valid;
   logic [63:0] abs_addr;
   logic        prot_fault;
   logic [63:0] exc_code;
   logic        wr_inval;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic        e_valid = 1'b0;
   logic [63:0] e_abs = '0;
   logic        e_fault = 1'b0;
   logic [63:0] e_exc = '0;
   logic        e_inval = 1'b0;
   string       e_tag = "R10";

   always #4 clk = ~clk;

   lap_prefix_map u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_kind(req_kind), .lap_en(lap_en), .xlate_on(xlate_on),
      .priv_space(priv_space), .prefix_base(prefix_base),
      .rsp_valid(rsp_valid), .abs_addr(abs_addr), .prot_fault(prot_fault),
      .exc_code(exc_code), .wr_inval(wr_inval)
   );

   function automatic bit in_low(longint unsigned x);
      return (x <= 511) || (x >= 4096 && x <= 4607);
   endfunction

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R10", "rsp_valid", 64'(rsp_valid), 64'(e_valid));
      chk(e_tag, "abs_addr", abs_addr, e_abs);
      chk(e_tag, "prot_fault", 64'(prot_fault), 64'(e_fault));
      chk(e_tag, "exc_code", exc_code, e_exc);
      chk(e_tag, "wr_inval", 64'(wr_inval), 64'(e_inval));
   endtask

   // One cycle: check the previous result, then drive and predict.
   task automatic step(bit v, longint unsigned a, int k, bit en, bit xl, bit pv,
                       longint unsigned p, string tag);
      longint unsigned pa, pf, ab, cd;
      bit act, st;
      @(negedge clk);
      compare_all();
      req_valid = v; req_addr = a; req_kind = 2'(k); lap_en = en;
      xlate_on = xl; priv_space = pv; prefix_base = p;
      e_valid = v;
      e_tag = tag;
      if (v) begin
         pa = a - (a % 4096);
         pf = p - (p % 8192);
         st = (k == 1);
         act = en && (!xl || !pv);
         if (pa < 8192) ab = pa + pf;
         else if (pa >= pf && pa < pf + 8192) ab = pa - pf;
         else ab = pa;
         e_fault = act && st && in_low(a);
         e_inval = act && in_low(pa);
         cd = pa + (st ? 1024 : 2048) + (e_fault ? 128 : 0);
         e_abs = ab;
         e_exc = cd;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      compare_all();
      rst_n = 1'b1;
      // R1 window edges for stores, guard active, translation off
      step(1, 0,    1, 1, 0, 0, 64'h4_0000, "R1");
      step(1, 511,  1, 1, 0, 0, 64'h4_0000, "R1");
      step(1, 512,  1, 1, 0, 0, 64'h4_0000, "R1");
      step(1, 4095, 1, 1, 0, 0, 64'h4_0000, "R1");
      step(1, 4096, 1, 1, 0, 0, 64'h4_0000, "R1");
      step(1, 4607, 1, 1, 0, 0, 64'h4_0000, "R1");
      step(1, 4608, 1, 1, 0, 0, 64'h4_0000, "R1");
      step(1, 64'h9000, 1, 1, 0, 0, 64'h4_0000, "R1");
      // R2 guard disabled
      step(1, 100,  1, 0, 0, 0, 64'h6_0000, "R2");
      step(1, 4100, 0, 0, 1, 0, 64'h6_0000, "R2");
      // R3 translation and private-space combinations
      step(1, 200,  1, 1, 0, 1, 64'h8_0000, "R3");
      step(1, 200,  1, 1, 1, 1, 64'h8_0000, "R3");
      step(1, 200,  1, 1, 1, 0, 64'h8_0000, "R3");
      // R4 loads and fetches flag the page without fault
      step(1, 600,  0, 1, 0, 0, 64'h8_0000, "R4");
      step(1, 4700, 2, 1, 1, 0, 64'h8_0000, "R4");
      step(1, 600,  1, 1, 0, 0, 64'h8_0000, "R4");
      // R5 fault code bit
      step(1, 4200, 1, 1, 0, 0, 64'h2_0000, "R5");
      // R6 direction bits on high addresses
      step(1, 64'h1234_5678, 0, 1, 0, 0, 64'h2_0000, "R6");
      step(1, 64'h1234_5678, 1, 1, 0, 0, 64'h2_0000, "R6");
      step(1, 64'h1234_5678, 2, 1, 0, 0, 64'h2_0000, "R6");
      // R7 low block goes to prefix; R8 prefix block goes to zero
      step(1, 64'h1FFF, 0, 0, 0, 0, 64'h10_0000, "R7");
      step(1, 64'h10_0000, 0, 0, 0, 0, 64'h10_0000, "R8");
      step(1, 64'h10_1FFF, 1, 1, 0, 0, 64'h10_0000, "R8");
      step(1, 64'h10_2000, 1, 1, 0, 0, 64'h10_0000, "R8");
      step(1, 64'h0F_F000, 0, 1, 0, 0, 64'h10_0000, "R8");
      step(1, 64'h3000, 0, 1, 0, 0, 64'h0, "R8");
      // R9 misaligned prefix
      step(1, 64'h1000, 0, 1, 0, 0, 64'h10_1ABC, "R9");
      step(1, 64'h10_1000, 0, 1, 0, 0, 64'h10_1ABC, "R9");
      // R10 idle cycles hold outputs
      step(0, 64'h5555, 1, 1, 0, 0, 64'h0, "R10");
      step(0, 0, 1, 1, 0, 0, 64'h0, "R10");
      // Mixed random traffic, including overlap of guard and swap
      for (int i = 0; i < 600; i++) begin
         longint unsigned a, p;
         int sel;
         p = 64'($urandom_range(0, 32'h3FFF_FFFF)) << 4;
         sel = $urandom_range(0, 3);
         if (sel == 0) a = 64'($urandom_range(0, 8191));
         else if (sel == 1) a = p - (p % 8192) + 64'($urandom_range(0, 8191));
         else if (sel == 2) a = 64'($urandom_range(0, 16383));
         else a = {32'($urandom), 32'($urandom)} >> 2;
         step(($urandom_range(0, 4) != 0), a, $urandom_range(0, 2),
              1'($urandom), 1'($urandom), 1'($urandom), p, "R8");
      end
      @(negedge clk);
      compare_all();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL R10 watchdog actual=%0d expected=%0d", cycles, 100000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule